// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits on the host side of a parallel NOR flash and converts one high-level request into the series of bus write cycles the flash command interpreter expects. A request (program, sector erase, chip erase or reset) is taken on a valid/ready handshake. The block then drives each write of the command sequence onto the address and data outputs and pulses an active-low write strobe for a set number of clocks. It leaves a set number of idle clocks between writes.

Program and both erase requests begin with a two-write unlock prefix, and each operation ends with its own final write. Once the last write has finished, the block hands off to an external status poller and waits for its verdict. It then reports a single-cycle response. The reset request is a single write that needs no polling. Addressing is word-based. While a request is in flight, no new request is accepted.

Top module: `nor_cmd_seq`

## Requirements
- R1: While and directly after reset, `req_ready` is 1, `bus_wr_n` is 1, and `poll_go` and `rsp_valid` are 0. A reset taken in the middle of a sequence ends that sequence: the strobe goes high and the block becomes ready again.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. The `req_op` encoding is 00 program, 01 sector erase, 10 chip erase, 11 reset. `req_ready` is 0 from the cycle after acceptance through the cycle in which `rsp_valid` is 1. Requests offered during that time produce no bus writes.
- R3: A program request produces four writes, as data@address: AAh@555h, 55h@2AAh, A0h@555h, then `req_data`@`req_addr`.
- R4: A sector erase request produces six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h@`req_addr`.
- R5: A chip erase request produces the same first five writes as R4, then 10h@555h.
- R6: A reset request produces one write, F0h@000h, and never asserts `poll_go`. `rsp_valid` rises with `rsp_fail` 0 in the cycle after that write's idle gap ends.
- R7: Each write holds `bus_wr_n` low for exactly WR_LOW clock cycles, with `bus_addr` and `bus_wdata` stable throughout. Consecutive writes are separated by exactly WR_GAP high cycles. Command bytes are zero-extended to the data width.
- R8: For program and erase requests, `poll_go` is 1 for one cycle, in the cycle after the last write's gap. `poll_done` is then awaited for any number of cycles. `rsp_valid` is 1 for one cycle, in the cycle after `poll_done` is sampled high, and `rsp_fail` equals `poll_fail` as sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | AW | Target word address or sector address |
| req_data | input | DW | Word to program |
| bus_addr | output | AW | Flash address for the current write |
| bus_wdata | output | DW | Flash data for the current write |
| bus_wr_n | output | 1 | Active-low write strobe |
| poll_go | output | 1 | One-cycle start for the status poller |
| poll_done | input | 1 | Poller finished |
| poll_fail | input | 1 | Poller reports failure, valid with poll_done |
| rsp_valid | output | 1 | One-cycle completion of the request |
| rsp_fail | output | 1 | Completion carries a failure |

## Verification
After acceptance, the first strobe falls in the very next cycle. Each write then stays low for WR_LOW cycles and high for WR_GAP cycles. `poll_go` or, for reset, `rsp_valid` appears one cycle after the final gap, and `rsp_valid` follows `poll_done` by one cycle.

The bench drives inputs and samples outputs on the falling clock edge, so each check reads the first cycle in which a result is due. It measures every low run and every high run of the strobe and compares each against these counts. It also confirms that `ready` returns in the cycle right after the response.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_RESET  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_GAP,
        ST_POLL_GO,
        ST_POLL_WAIT,
        ST_RESP
    } st_e;

    typedef enum logic [1:0] {
        A_UNLK1,
        A_UNLK2,
        A_TGT,
        A_ZERO
    } asel_e;

    typedef struct packed {
        asel_e      asel;
        logic       use_tdata;
        logic [7:0] cmd;
    } step_t;

    localparam int STEP_W = 3;

    localparam logic [7:0]  CMD_UNLK1 = 8'hAA;
    localparam logic [7:0]  CMD_UNLK2 = 8'h55;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;
    localparam logic [7:0]  CMD_RST   = 8'hF0;
    localparam logic [11:0] ADR_UNLK1 = 12'h555;
    localparam logic [11:0] ADR_UNLK2 = 12'h2AA;

    function automatic logic [STEP_W-1:0] last_step(op_e op);
        case (op)
            OP_PROG:  return STEP_W'(3);
            OP_RESET: return STEP_W'(0);
            default:  return STEP_W'(5);
        endcase
    endfunction

    function automatic logic needs_poll(op_e op);
        return op != OP_RESET;
    endfunction

    function automatic step_t step_decode(op_e op, logic [STEP_W-1:0] idx);
        step_t s;
        s = '{asel: A_UNLK1, use_tdata: 1'b0, cmd: CMD_UNLK1};
        if (op == OP_RESET) begin
            s.asel = A_ZERO;
            s.cmd  = CMD_RST;
        end else begin
            case (idx)
                3'd1, 3'd4: begin
                    s.asel = A_UNLK2;
                    s.cmd  = CMD_UNLK2;
                end
                3'd2: s.cmd = (op == OP_PROG) ? CMD_PROG : CMD_ERASE;
                3'd3: begin
                    if (op == OP_PROG) begin
                        s.asel      = A_TGT;
                        s.use_tdata = 1'b1;
                    end
                end
                3'd5: begin
                    if (op == OP_SERASE) begin
                        s.asel = A_TGT;
                        s.cmd  = CMD_SECT;
                    end else begin
                        s.cmd  = CMD_CHIP;
                    end
                end
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
    parameter int LOW_CYC = 3,
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic in_strobe,
    output logic expire
);
    localparam int MAXC = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim    = in_strobe ? CW'(LOW_CYC - 1) : CW'(GAP_CYC - 1);
    assign expire = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= lim);

endmodule

// File: rtl/nor_step_mux.sv
module nor_step_mux
    import nor_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] idx,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     data
);
    step_t s;

    always_comb begin
        s = step_decode(op, idx);
        case (s.asel)
            A_UNLK1: addr = AW'(ADR_UNLK1);
            A_UNLK2: addr = AW'(ADR_UNLK2);
            A_TGT:   addr = tgt_addr;
            default: addr = '0;
        endcase
        data = s.use_tdata ? tgt_data : DW'(s.cmd);
    end

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic              expire,
    input  logic              poll_done,
    input  logic              poll_fail,
    output logic              req_ready,
    output logic              accept,
    output logic              strobe_on,
    output logic              timer_run,
    output logic              poll_go,
    output logic              rsp_valid,
    output logic              rsp_fail,
    output op_e               op_q,
    output logic [STEP_W-1:0] idx
);
    st_e  state;
    logic fail_q;

    assign req_ready = state == ST_IDLE;
    assign accept    = req_ready && req_valid;
    assign strobe_on = state == ST_STROBE;
    assign timer_run = (state == ST_STROBE) || (state == ST_GAP);
    assign poll_go   = state == ST_POLL_GO;
    assign rsp_valid = state == ST_RESP;
    assign rsp_fail  = rsp_valid && fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_RESET;
            idx    <= '0;
            fail_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_STROBE;
                    op_q   <= req_op;
                    idx    <= '0;
                    fail_q <= 1'b0;
                end
                ST_STROBE: if (expire) state <= ST_GAP;
                ST_GAP: if (expire) begin
                    if (idx == last_step(op_q))
                        state <= needs_poll(op_q) ? ST_POLL_GO : ST_RESP;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= ST_STROBE;
                    end
                end
                ST_POLL_GO: state <= ST_POLL_WAIT;
                ST_POLL_WAIT: if (poll_done) begin
                    fail_q <= poll_fail;
                    state  <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R8
    poll_go_single_chk: assert property (@(posedge clk) disable iff (rst)
        poll_go |=> !poll_go && !rsp_valid);

    // R8
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R6
    reset_no_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(state) == ST_GAP) |-> op_q == OP_RESET);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int WR_LOW = 3,
    parameter int WR_GAP = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr_n,
    output logic          poll_go,
    input  logic          poll_done,
    input  logic          poll_fail,
    output logic          rsp_valid,
    output logic          rsp_fail
);
    logic              accept, strobe_on, timer_run, expire;
    op_e               op_q;
    logic [STEP_W-1:0] idx;
    logic [AW-1:0]     tgt_addr;
    logic [DW-1:0]     tgt_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_addr <= '0;
            tgt_data <= '0;
        end else if (accept) begin
            tgt_addr <= req_addr;
            tgt_data <= req_data;
        end
    end

    nor_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .expire    (expire),
        .poll_done (poll_done),
        .poll_fail (poll_fail),
        .req_ready (req_ready),
        .accept    (accept),
        .strobe_on (strobe_on),
        .timer_run (timer_run),
        .poll_go   (poll_go),
        .rsp_valid (rsp_valid),
        .rsp_fail  (rsp_fail),
        .op_q      (op_q),
        .idx       (idx)
    );

    nor_phase_timer #(.LOW_CYC(WR_LOW), .GAP_CYC(WR_GAP)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (timer_run),
        .in_strobe (strobe_on),
        .expire    (expire)
    );

    nor_step_mux #(.AW(AW), .DW(DW)) u_mux (
        .op       (op_q),
        .idx      (idx),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .addr     (bus_addr),
        .data     (bus_wdata)
    );

    assign bus_wr_n = !strobe_on;

    // R7
    bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    // R1
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({poll_go, rsp_valid, !bus_wr_n}));

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int WR_LOW = 3;
    localparam int WR_GAP = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] addr;
        logic [15:0] data;
        logic        fail;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 20'h12345, 16'hBEEF, 1'b0, 4'd0},
        '{2'b01, 20'h48000, 16'h0000, 1'b0, 4'd3},
        '{2'b10, 20'h00000, 16'h0000, 1'b0, 4'd1},
        '{2'b11, 20'h00000, 16'h0000, 1'b0, 4'd0},
        '{2'b00, 20'hFFFFF, 16'h0001, 1'b1, 4'd6},
        '{2'b01, 20'h08000, 16'h0000, 1'b1, 4'd2},
        '{2'b00, 20'h00555, 16'hA5A5, 1'b0, 4'd4}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          req_valid = 0;
    logic          req_ready;
    logic [1:0]    req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_data = 0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wr_n;
    logic          poll_go;
    logic          poll_done = 0;
    logic          poll_fail = 0;
    logic          rsp_valid;
    logic          rsp_fail;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .WR_LOW(WR_LOW), .WR_GAP(WR_GAP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr_n(bus_wr_n),
        .poll_go(poll_go), .poll_done(poll_done), .poll_fail(poll_fail),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [1:0] op);
        case (op)
            2'b00:   return 4;
            2'b11:   return 1;
            default: return 6;
        endcase
    endfunction

    function automatic logic [35:0] exp_wr(input logic [1:0] op, input int k,
                                           input logic [19:0] a, input logic [15:0] d);
        if (op == 2'b11) return {20'h00000, 16'h00F0};
        case (k)
            0: return {20'h00555, 16'h00AA};
            1: return {20'h002AA, 16'h0055};
            2: return (op == 2'b00) ? {20'h00555, 16'h00A0} : {20'h00555, 16'h0080};
            3: return (op == 2'b00) ? {a, d} : {20'h00555, 16'h00AA};
            4: return {20'h002AA, 16'h0055};
            default: return (op == 2'b01) ? {a, 16'h0030} : {20'h00555, 16'h0010};
        endcase
    endfunction

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // Runs one request; entered and left on a falling edge.
    task automatic run_op(input vec_t v);
        int n = 0;
        int lowlen = 0;
        int gaplen = 0;
        bit prev = 1;
        bit fin = 0;
        bit stable_bad = 0;
        bit busy_ready = 0;
        logic [19:0] la = 0;
        logic [15:0] ld = 0;
        logic [35:0] e;
        string rq = op_req(v.op);
        chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid = 1; req_op = v.op; req_addr = v.addr; req_data = v.data;
        for (int c = 0; c < 400 && !fin; c++) begin
            @(negedge clk);
            // R2: keep offering a different request while busy
            req_op = 2'b10; req_addr = 20'h0F0F0; req_data = 16'h7777;
            if (req_ready) busy_ready = 1;
            if (!bus_wr_n) begin
                if (prev) begin
                    if (n > 0) chk(gaplen == WR_GAP, "R7", "gap length", gaplen, WR_GAP);
                    if (n < exp_count(v.op)) begin
                        e = exp_wr(v.op, n, v.addr, v.data);
                        chk(bus_addr == e[35:16], rq, "write address", bus_addr, e[35:16]);
                        chk(bus_wdata == e[15:0], rq, "write data", bus_wdata, e[15:0]);
                    end
                    la = bus_addr; ld = bus_wdata;
                    n++;
                    lowlen = 1;
                end else begin
                    lowlen++;
                    if (bus_addr != la || bus_wdata != ld) stable_bad = 1;
                end
            end else begin
                if (!prev) begin
                    chk(lowlen == WR_LOW, "R7", "strobe low length", lowlen, WR_LOW);
                    gaplen = 1;
                end else gaplen++;
            end
            prev = bus_wr_n;
            if (poll_go || rsp_valid) fin = 1;
        end
        chk(fin, rq, "sequence finished", fin, 1);
        chk(n == exp_count(v.op), rq, "write count", n, exp_count(v.op));
        chk(!stable_bad, "R7", "bus stable in strobe", stable_bad, 0);
        chk(!busy_ready, "R2", "ready low while busy", busy_ready, 0);
        chk(gaplen == WR_GAP + 1, "R8", "handoff cycle after gap", gaplen, WR_GAP + 1);
        if (v.op == 2'b11) begin
            chk(rsp_valid && !poll_go, "R6", "reset responds without poll", {poll_go, rsp_valid}, 1);
            chk(rsp_fail == 1'b0, "R6", "reset rsp_fail", rsp_fail, 0);
        end else begin
            chk(poll_go && !rsp_valid, "R8", "poll_go raised", {poll_go, rsp_valid}, 2);
            for (int k = 0; k <= int'(v.dly); k++) begin
                @(negedge clk);
                chk(!poll_go && !rsp_valid, "R8", "waiting for poller", {poll_go, rsp_valid}, 0);
            end
            poll_done = 1; poll_fail = v.fail;
            @(negedge clk);
            poll_done = 0; poll_fail = 0;
            chk(rsp_valid == 1'b1, "R8", "rsp_valid after poll_done", rsp_valid, 1);
            chk(rsp_fail == v.fail, "R8", "rsp_fail", rsp_fail, v.fail);
            chk(req_ready == 1'b0, "R2", "ready low with rsp", req_ready, 0);
        end
        req_valid = 0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid one cycle", rsp_valid, 0);
        chk(req_ready == 1'b1, "R2", "ready after rsp", req_ready, 1);
        chk(bus_wr_n == 1'b1, "R2", "no write from busy offer", bus_wr_n, 1);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(bus_wr_n == 1'b1, "R1", "strobe in reset", bus_wr_n, 1);
        chk(!poll_go && !rsp_valid, "R1", "pulses in reset", {poll_go, rsp_valid}, 0);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_wr_n == 1'b1, "R1", "state after reset", {req_ready, bus_wr_n}, 3);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R1: reset in the middle of a program sequence
        req_valid = 1; req_op = 2'b00; req_addr = 20'h00100; req_data = 16'h1234;
        @(negedge clk);
        req_valid = 0;
        repeat (WR_LOW + WR_GAP) @(negedge clk);
        chk(bus_wr_n == 1'b0 && req_ready == 1'b0, "R1", "second write under way",
            {bus_wr_n, req_ready}, 0);
        rst = 1;
        @(negedge clk);
        chk(bus_wr_n == 1'b1, "R1", "strobe released by reset", bus_wr_n, 1);
        chk(req_ready == 1'b1, "R1", "ready after mid reset", req_ready, 1);
        rst = 0;
        @(negedge clk);
        chk(bus_wr_n == 1'b1 && !poll_go, "R1", "quiet after mid reset", {bus_wr_n, poll_go}, 2);
        run_op(VECS[2]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule